// File: doc/BRIEF.md
# Miss status holding register file

This block keeps track of outstanding cache misses in a fixed pool of entries. Each live entry records a block address, a request size, the time from which it may be issued, the thread that owns it, and whether it is currently in service. A cache controller drives one operation per clock to change this state. It can allocate a miss, free an entry, send an entry into service or bring it back to pending, move an entry to the head of the issue order, or squash all entries of one thread.

Lookups are combinational and run every cycle beside the operation port. An exact-address match searches the allocated entries. An overlap match searches the ready entries with an address and a size. The issue select output names the ready entry that should be sent next, given the current time.

The pool holds the normal entry count plus the spare count minus one. A stack of free indices hands out entries. The first-allocated order and the ready order are each held as a relative-age matrix, so no entry is ever physically moved.

Top module: `mshr_file`

## Requirements
- R1: The pool holds NUM_NORMAL + NUM_SPARE - 1 entries. When every entry is allocated, `full` is 1 and an allocate operation changes no state.
- R2: After reset, allocations take entries 0, 1, 2, … in turn. An entry that is freed goes on top of the free stack, so `alloc_idx` names it and the next allocation reuses it.
- R3: The exact lookup hits when an allocated entry's address equals `look_addr`, in service or not. If several entries match, `match_idx` names the one allocated earliest.
- R4: The issue select considers only ready entries (allocated, not in service) whose ready time is at or before `now_time`. Among those it picks the smallest ready time. On equal times it picks the entry that entered the ready order first.
- R5: The overlap lookup considers ready entries only. Take an entry at address E with size S, and a query at address Q with size Z. If E < Q, the entry hits when E + S > Q. Otherwise it hits when Q + Z > E.
- R6: Issue (op code 3) on a ready entry sets it in service, removes it from the ready order and raises `insvc_cnt` by one. If `op_no_resp` is 1, the entry is freed at once instead. Issue on an entry that is not ready has no effect.
- R7: Retry (op code 4) on an in-service entry clears its in-service state, lowers `insvc_cnt` and re-enters the entry as the newest member of the ready order. Retry on any other entry has no effect.
- R8: Promote (op code 5) on a ready entry makes the issue select prefer it over every unpromoted eligible entry. Among promoted entries, the one promoted last is preferred. Promote on an in-service entry has no effect.
- R9: Free (op code 2) releases an allocated entry and lowers `alloc_cnt`. If the entry was in service it also lowers `insvc_cnt`. Free on an unallocated entry has no effect.
- R10: Squash (op code 6) releases every ready entry whose thread equals `op_tid`. Matching entries that are in service stay allocated and stay in service.
- R11: Op codes: 0 none, 1 allocate (into the entry named by `alloc_idx`, with the `op_addr`, `op_size`, `op_time` and `op_tid` fields). All effects appear from the clock edge that samples the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_time | input | TIME_W | Current time, used by the issue select |
| op | input | 3 | Operation code (R11) |
| op_idx | input | IDX_W | Target entry for free, issue, retry and promote |
| op_addr | input | ADDR_W | Block address for allocate |
| op_size | input | SIZE_W | Request size for allocate |
| op_time | input | TIME_W | Ready time for allocate |
| op_tid | input | TID_W | Thread for allocate and squash |
| op_no_resp | input | 1 | With issue: free the entry at once |
| look_addr | input | ADDR_W | Query address for both lookups |
| look_size | input | SIZE_W | Query size for the overlap lookup |
| full | output | 1 | No free entry |
| alloc_idx | output | IDX_W | Entry the next allocation takes |
| alloc_cnt | output | CNT_W | Number of allocated entries |
| insvc_cnt | output | CNT_W | Number of in-service entries |
| match_hit | output | 1 | Exact lookup hit |
| match_idx | output | IDX_W | Entry found by the exact lookup |
| ovl_hit | output | 1 | Overlap lookup hit |
| ovl_idx | output | IDX_W | First ready entry found by the overlap lookup |
| sel_valid | output | 1 | An entry is eligible for issue |
| sel_idx | output | IDX_W | Entry chosen for issue |

## Verification
The bench builds the block with NUM_NORMAL = 3 and NUM_SPARE = 2, so the sum-minus-one sizing gives four entries, the same as the default by a different route. With only four entries, the pool fills in four allocations. That puts rejection, stack reuse after a squash and a free, and ties between equal ready times within a short table. Sixteen-bit addresses and times let the bench place overlap queries one byte inside and one byte outside an entry's edges. It also moves `now_time` past a later ready time to change which entries are eligible.

// File: rtl/mshr_pkg.sv
package mshr_pkg;

   typedef enum logic [2:0] {
      OP_NONE    = 3'd0,
      OP_ALLOC   = 3'd1,
      OP_FREE    = 3'd2,
      OP_ISSUE   = 3'd3,
      OP_RETRY   = 3'd4,
      OP_PROMOTE = 3'd5,
      OP_SQUASH  = 3'd6
   } mshr_op_e;

endpackage

// File: rtl/mshr_free_stack.sv
// LIFO of free entry indices; several pushes may land in one cycle.
module mshr_free_stack #(
   parameter int N     = 4,
   parameter int IDX_W = 2,
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pop,
   input  logic [N-1:0]     push_mask,
   output logic [IDX_W-1:0] top_idx,
   output logic             empty
);
   localparam logic [CNT_W-1:0] N_C = CNT_W'(N);

   logic [IDX_W-1:0] stk_q [N];
   logic [IDX_W-1:0] stk_d [N];
   logic [CNT_W-1:0] cnt_q, cnt_d, top_pos;

   assign top_pos = cnt_q - CNT_W'(1);
   assign top_idx = stk_q[top_pos[IDX_W-1:0]];
   assign empty   = (cnt_q == '0);

   always_comb begin
      for (int k = 0; k < N; k++) stk_d[k] = stk_q[k];
      cnt_d = cnt_q;
      if (pop && cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
      for (int i = 0; i < N; i++) begin
         if (push_mask[i] && cnt_d < N_C) begin
            stk_d[cnt_d[IDX_W-1:0]] = IDX_W'(i);
            cnt_d = cnt_d + CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < N; k++) stk_q[k] <= IDX_W'(N - 1 - k);
         cnt_q <= N_C;
      end else begin
         for (int k = 0; k < N; k++) stk_q[k] <= stk_d[k];
         cnt_q <= cnt_d;
      end
   end
endmodule

// File: rtl/mshr_age_matrix.sv
// older_q[i][j] = 1 when entry i entered the order before entry j.
module mshr_age_matrix #(
   parameter int N = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N-1:0]          ins,
   output logic [N-1:0][N-1:0]   older
);
   logic [N-1:0][N-1:0] older_q;
   assign older = older_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         older_q <= '0;
      end else begin
         for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
               if (i != j) begin
                  if (ins[j])      older_q[i][j] <= 1'b1;
                  else if (ins[i]) older_q[i][j] <= 1'b0;
               end
            end
         end
      end
   end
endmodule

// File: rtl/mshr_pick.sv
// Chooses the requester that is preferred over every other requester.
module mshr_pick #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]          req,
   input  logic [N-1:0][N-1:0]   pref,
   output logic                  valid,
   output logic [IDX_W-1:0]      idx
);
   logic [N-1:0] win;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         win[i] = req[i];
         for (int j = 0; j < N; j++) begin
            win[i] = win[i] & ((i == j) | ~req[j] | pref[i][j]);
         end
      end
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) if (win[i]) idx = IDX_W'(i);
   end

   assign valid = |win;
endmodule

// File: rtl/mshr_file.sv
module mshr_file
   import mshr_pkg::*;
#(
   parameter int NUM_NORMAL = 4,
   parameter int NUM_SPARE  = 1,
   parameter int ADDR_W     = 16,
   parameter int SIZE_W     = 8,
   parameter int TIME_W     = 16,
   parameter int TID_W      = 2,
   localparam int N         = NUM_NORMAL + NUM_SPARE - 1,
   localparam int IDX_W     = $clog2(N),
   localparam int CNT_W     = $clog2(N + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] now_time,
   input  logic [2:0]        op,
   input  logic [IDX_W-1:0]  op_idx,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [SIZE_W-1:0] op_size,
   input  logic [TIME_W-1:0] op_time,
   input  logic [TID_W-1:0]  op_tid,
   input  logic              op_no_resp,
   input  logic [ADDR_W-1:0] look_addr,
   input  logic [SIZE_W-1:0] look_size,
   output logic              full,
   output logic [IDX_W-1:0]  alloc_idx,
   output logic [CNT_W-1:0]  alloc_cnt,
   output logic [CNT_W-1:0]  insvc_cnt,
   output logic              match_hit,
   output logic [IDX_W-1:0]  match_idx,
   output logic              ovl_hit,
   output logic [IDX_W-1:0]  ovl_idx,
   output logic              sel_valid,
   output logic [IDX_W-1:0]  sel_idx
);
   localparam int AW1 = ADDR_W + 1;

   // elaboration-time parameter checks
   generate
      if (NUM_NORMAL < 1 || NUM_SPARE < 1) begin : g_bad_counts
         $error("mshr_file: NUM_NORMAL and NUM_SPARE must be at least 1");
      end
      if (N < 2) begin : g_bad_depth
         $error("mshr_file: pool needs at least two entries");
      end
      if (SIZE_W > ADDR_W) begin : g_bad_size
         $error("mshr_file: SIZE_W must not exceed ADDR_W");
      end
   endgenerate

   mshr_op_e op_e;
   assign op_e = mshr_op_e'(op);

   // entry state
   logic [N-1:0]        vld_q, svc_q, pro_q;
   logic [ADDR_W-1:0]   addr_q [N];
   logic [SIZE_W-1:0]   size_q [N];
   logic [TIME_W-1:0]   time_q [N];
   logic [TID_W-1:0]    tid_q  [N];
   logic [N-1:0]        rdy_vec;

   assign rdy_vec = vld_q & ~svc_q;

   // operation decode
   logic [N-1:0] tgt, alloc_oh, free_mask, rq_ins, squash_mask;
   logic         stk_empty;
   logic         do_alloc, do_free, do_issue, issue_free, do_retry, do_promote;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         tgt[i]         = (op_idx == IDX_W'(i));
         alloc_oh[i]    = (alloc_idx == IDX_W'(i));
         squash_mask[i] = rdy_vec[i] && (tid_q[i] == op_tid);
      end
   end

   assign full       = stk_empty;
   assign do_alloc   = (op_e == OP_ALLOC)   && !stk_empty;
   assign do_free    = (op_e == OP_FREE)    && vld_q[op_idx];
   assign do_issue   = (op_e == OP_ISSUE)   && rdy_vec[op_idx];
   assign issue_free = do_issue && op_no_resp;
   assign do_retry   = (op_e == OP_RETRY)   && vld_q[op_idx] && svc_q[op_idx];
   assign do_promote = (op_e == OP_PROMOTE) && rdy_vec[op_idx];

   assign free_mask = ((op_e == OP_SQUASH) ? squash_mask : '0)
                    | (tgt & {N{do_free | issue_free}});
   assign rq_ins    = (alloc_oh & {N{do_alloc}})
                    | (tgt & {N{do_retry | do_promote}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         svc_q <= '0;
         pro_q <= '0;
      end else begin
         for (int i = 0; i < N; i++) begin
            if (do_alloc && alloc_oh[i]) begin
               vld_q[i] <= 1'b1;
               svc_q[i] <= 1'b0;
               pro_q[i] <= 1'b0;
            end else if (free_mask[i]) begin
               vld_q[i] <= 1'b0;
               svc_q[i] <= 1'b0;
               pro_q[i] <= 1'b0;
            end else if (tgt[i] && do_issue) begin
               svc_q[i] <= 1'b1;
               pro_q[i] <= 1'b0;
            end else if (tgt[i] && do_retry) begin
               svc_q[i] <= 1'b0;
               pro_q[i] <= 1'b0;
            end else if (tgt[i] && do_promote) begin
               pro_q[i] <= 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < N; i++) begin
         if (do_alloc && alloc_oh[i]) begin
            addr_q[i] <= op_addr;
            size_q[i] <= op_size;
            time_q[i] <= op_time;
            tid_q[i]  <= op_tid;
         end
      end
   end

   // free list
   mshr_free_stack #(.N(N), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_free (
      .clk       (clk),
      .rst_n     (rst_n),
      .pop       (do_alloc),
      .push_mask (free_mask),
      .top_idx   (alloc_idx),
      .empty     (stk_empty)
   );

   // allocation order and ready order
   logic [N-1:0][N-1:0] aold, rold, rpref;

   mshr_age_matrix #(.N(N)) u_alloc_age (
      .clk   (clk),
      .rst_n (rst_n),
      .ins   (alloc_oh & {N{do_alloc}}),
      .older (aold)
   );

   mshr_age_matrix #(.N(N)) u_ready_age (
      .clk   (clk),
      .rst_n (rst_n),
      .ins   (rq_ins),
      .older (rold)
   );

   // ready-order preference: promoted (newest first), then time, then age
   always_comb begin
      for (int i = 0; i < N; i++) begin
         for (int j = 0; j < N; j++) begin
            if (pro_q[i])
               rpref[i][j] = !pro_q[j] || rold[j][i];
            else
               rpref[i][j] = !pro_q[j] &&
                             ((time_q[i] < time_q[j]) ||
                              ((time_q[i] == time_q[j]) && rold[i][j]));
         end
      end
   end

   // lookup request vectors
   logic [N-1:0]   elig, amatch, omatch;
   logic [AW1-1:0] q_end;
   assign q_end = AW1'(look_addr) + AW1'(look_size);

   always_comb begin
      for (int i = 0; i < N; i++) begin
         elig[i]   = rdy_vec[i] && (time_q[i] <= now_time);
         amatch[i] = vld_q[i] && (addr_q[i] == look_addr);
         if (addr_q[i] < look_addr)
            omatch[i] = rdy_vec[i] &&
                        ((AW1'(addr_q[i]) + AW1'(size_q[i])) > AW1'(look_addr));
         else
            omatch[i] = rdy_vec[i] && (q_end > AW1'(addr_q[i]));
      end
   end

   mshr_pick #(.N(N), .IDX_W(IDX_W)) u_pick_sel (
      .req(elig), .pref(rpref), .valid(sel_valid), .idx(sel_idx));

   mshr_pick #(.N(N), .IDX_W(IDX_W)) u_pick_ovl (
      .req(omatch), .pref(rpref), .valid(ovl_hit), .idx(ovl_idx));

   mshr_pick #(.N(N), .IDX_W(IDX_W)) u_pick_match (
      .req(amatch), .pref(aold), .valid(match_hit), .idx(match_idx));

   // occupancy counts
   always_comb begin
      alloc_cnt = '0;
      insvc_cnt = '0;
      for (int i = 0; i < N; i++) begin
         alloc_cnt = alloc_cnt + CNT_W'(vld_q[i]);
         insvc_cnt = insvc_cnt + CNT_W'(svc_q[i]);
      end
   end

   logic [TIME_W-1:0] sel_time;
   assign sel_time = time_q[sel_idx];
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk
   import mshr_pkg::*;
#(
   parameter int N      = 4,
   parameter int IDX_W  = 2,
   parameter int CNT_W  = 3,
   parameter int TIME_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        op,
   input logic [IDX_W-1:0]  op_idx,
   input logic              op_no_resp,
   input logic [N-1:0]      rdy_vec,
   input logic              full,
   input logic [CNT_W-1:0]  alloc_cnt,
   input logic [CNT_W-1:0]  insvc_cnt,
   input logic              sel_valid,
   input logic [IDX_W-1:0]  sel_idx,
   input logic [TIME_W-1:0] sel_time,
   input logic [TIME_W-1:0] now_time
);
   localparam logic [CNT_W-1:0] N_C = CNT_W'(N);

   a_r1_reject_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ALLOC && full) |=> alloc_cnt == $past(alloc_cnt));

   a_r1_full_at_capacity: assert property (@(posedge clk) disable iff (!rst_n)
      full == (alloc_cnt == N_C));

   a_r6_issue_counts: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ISSUE && rdy_vec[op_idx] && !op_no_resp)
      |=> insvc_cnt == $past(insvc_cnt) + CNT_W'(1));

   a_r4_sel_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> (rdy_vec[sel_idx] && sel_time <= now_time));

   a_r10_squash_keeps_service: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SQUASH) |=> insvc_cnt == $past(insvc_cnt));

   a_r9_counts_ordered: assert property (@(posedge clk) disable iff (!rst_n)
      insvc_cnt <= alloc_cnt);
endmodule

bind mshr_file mshr_file_chk #(
   .N(N), .IDX_W(IDX_W), .CNT_W(CNT_W), .TIME_W(TIME_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op         (op),
   .op_idx     (op_idx),
   .op_no_resp (op_no_resp),
   .rdy_vec    (rdy_vec),
   .full       (full),
   .alloc_cnt  (alloc_cnt),
   .insvc_cnt  (insvc_cnt),
   .sel_valid  (sel_valid),
   .sel_idx    (sel_idx),
   .sel_time   (sel_time),
   .now_time   (now_time)
);

// File: tb/mshr_file_tb.sv
module mshr_file_tb;
   localparam int NN = 3;
   localparam int NS = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] now_time = 16'd100;
   logic [2:0]  op = 3'd0;
   logic [1:0]  op_idx = '0;
   logic [15:0] op_addr = '0;
   logic [7:0]  op_size = '0;
   logic [15:0] op_time = '0;
   logic [1:0]  op_tid = '0;
   logic        op_no_resp = 1'b0;
   logic [15:0] look_addr = '0;
   logic [7:0]  look_size = '0;
   logic        full, match_hit, ovl_hit, sel_valid;
   logic [1:0]  alloc_idx, match_idx, ovl_idx, sel_idx;
   logic [2:0]  alloc_cnt, insvc_cnt;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   mshr_file #(.NUM_NORMAL(NN), .NUM_SPARE(NS), .ADDR_W(16), .SIZE_W(8),
               .TIME_W(16), .TID_W(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .now_time(now_time), .op(op), .op_idx(op_idx),
      .op_addr(op_addr), .op_size(op_size), .op_time(op_time), .op_tid(op_tid),
      .op_no_resp(op_no_resp), .look_addr(look_addr), .look_size(look_size),
      .full(full), .alloc_idx(alloc_idx), .alloc_cnt(alloc_cnt),
      .insvc_cnt(insvc_cnt), .match_hit(match_hit), .match_idx(match_idx),
      .ovl_hit(ovl_hit), .ovl_idx(ovl_idx), .sel_valid(sel_valid),
      .sel_idx(sel_idx));

   typedef struct packed {
      logic [2:0]  op;
      logic [1:0]  idx;
      logic [15:0] addr;
      logic [7:0]  size;
      logic [15:0] tim;
      logic [1:0]  tid;
      logic        nores;
      logic [2:0]  e_cnt;
      logic [2:0]  e_svc;
      logic        e_sv;
      logic [1:0]  e_si;
      logic [1:0]  e_ai;
      logic        c_ai;
   } vec_t;

   // now_time = 100 throughout the table
   localparam vec_t TBL [16] = '{
      '{3'd1, 2'd0, 16'h0100, 8'd16, 16'd50,  2'd0, 1'b0, 3'd1, 3'd0, 1'b1, 2'd0, 2'd1, 1'b1}, // R2 first entry
      '{3'd1, 2'd0, 16'h0200, 8'd16, 16'd30,  2'd1, 1'b0, 3'd2, 3'd0, 1'b1, 2'd1, 2'd2, 1'b1}, // R4 smaller time
      '{3'd1, 2'd0, 16'h0100, 8'd8,  16'd30,  2'd0, 1'b0, 3'd3, 3'd0, 1'b1, 2'd1, 2'd3, 1'b1}, // R4 tie keeps arrival
      '{3'd1, 2'd0, 16'h0300, 8'd16, 16'd200, 2'd1, 1'b0, 3'd4, 3'd0, 1'b1, 2'd1, 2'd0, 1'b0}, // R4 future time
      '{3'd1, 2'd0, 16'h0500, 8'd16, 16'd10,  2'd0, 1'b0, 3'd4, 3'd0, 1'b1, 2'd1, 2'd0, 1'b0}, // R1 rejected
      '{3'd3, 2'd1, 16'h0000, 8'd0,  16'd0,   2'd0, 1'b0, 3'd4, 3'd1, 1'b1, 2'd2, 2'd0, 1'b0}, // R6 issue
      '{3'd5, 2'd0, 16'h0000, 8'd0,  16'd0,   2'd0, 1'b0, 3'd4, 3'd1, 1'b1, 2'd0, 2'd0, 1'b0}, // R8 promote
      '{3'd5, 2'd1, 16'h0000, 8'd0,  16'd0,   2'd0, 1'b0, 3'd4, 3'd1, 1'b1, 2'd0, 2'd0, 1'b0}, // R8 in service
      '{3'd4, 2'd1, 16'h0000, 8'd0,  16'd0,   2'd0, 1'b0, 3'd4, 3'd0, 1'b1, 2'd0, 2'd0, 1'b0}, // R7 retry
      '{3'd3, 2'd0, 16'h0000, 8'd0,  16'd0,   2'd0, 1'b0, 3'd4, 3'd1, 1'b1, 2'd2, 2'd0, 1'b0}, // R7 retried is newest
      '{3'd6, 2'd0, 16'h0000, 8'd0,  16'd0,   2'd0, 1'b0, 3'd3, 3'd1, 1'b1, 2'd1, 2'd2, 1'b1}, // R10 squash
      '{3'd2, 2'd0, 16'h0000, 8'd0,  16'd0,   2'd0, 1'b0, 3'd2, 3'd0, 1'b1, 2'd1, 2'd0, 1'b1}, // R9 free in service
      '{3'd3, 2'd1, 16'h0000, 8'd0,  16'd0,   2'd0, 1'b1, 3'd1, 3'd0, 1'b0, 2'd0, 2'd1, 1'b1}, // R6 no response
      '{3'd1, 2'd0, 16'h0400, 8'd16, 16'd100, 2'd2, 1'b0, 3'd2, 3'd0, 1'b1, 2'd1, 2'd0, 1'b1}, // R2 reuse
      '{3'd2, 2'd2, 16'h0000, 8'd0,  16'd0,   2'd0, 1'b0, 3'd2, 3'd0, 1'b1, 2'd1, 2'd0, 1'b1}, // R9 unallocated
      '{3'd4, 2'd3, 16'h0000, 8'd0,  16'd0,   2'd0, 1'b0, 3'd2, 3'd0, 1'b1, 2'd1, 2'd0, 1'b1}  // R7 not in service
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_op(input logic [2:0] o, input logic [1:0] i,
                        input logic [15:0] a, input logic [7:0] s,
                        input logic [15:0] t, input logic [1:0] th,
                        input logic nr);
      @(negedge clk);
      op = o; op_idx = i; op_addr = a; op_size = s;
      op_time = t; op_tid = th; op_no_resp = nr;
      @(posedge clk);
      #1;
      op = 3'd0; op_no_resp = 1'b0;
      #1;
   endtask

   task automatic look(input logic [15:0] a, input logic [7:0] s);
      look_addr = a; look_size = s;
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      do_reset();
      // reset state
      chk("R1 reset full", int'(full), 0);
      chk("R9 reset alloc_cnt", int'(alloc_cnt), 0);
      chk("R6 reset insvc_cnt", int'(insvc_cnt), 0);
      chk("R4 reset sel_valid", int'(sel_valid), 0);
      chk("R2 reset alloc_idx", int'(alloc_idx), 0);
      look(16'h0100, 8'd1);
      chk("R3 reset no match", int'(match_hit), 0);

      // table walk
      for (int k = 0; k < 16; k++) begin
         do_op(TBL[k].op, TBL[k].idx, TBL[k].addr, TBL[k].size,
               TBL[k].tim, TBL[k].tid, TBL[k].nores);
         chk($sformatf("R9 step %0d alloc_cnt", k), int'(alloc_cnt), int'(TBL[k].e_cnt));
         chk($sformatf("R6 step %0d insvc_cnt", k), int'(insvc_cnt), int'(TBL[k].e_svc));
         chk($sformatf("R4 step %0d sel_valid", k), int'(sel_valid), int'(TBL[k].e_sv));
         if (TBL[k].e_sv)
            chk($sformatf("R4 step %0d sel_idx", k), int'(sel_idx), int'(TBL[k].e_si));
         if (TBL[k].c_ai)
            chk($sformatf("R2 step %0d alloc_idx", k), int'(alloc_idx), int'(TBL[k].e_ai));
         if (k == 3)
            chk("R1 full after four", int'(full), 1);
      end

      // entries now: 1 {0x400,16,t100}, 3 {0x300,16,t200}
      look(16'h0300, 8'd1);
      chk("R3 exact hit", int'(match_hit), 1);
      chk("R3 exact idx", int'(match_idx), 3);
      look(16'h0500, 8'd1);
      chk("R3 exact miss", int'(match_hit), 0);
      look(16'h02F8, 8'd8);
      chk("R5 below edge miss", int'(ovl_hit), 0);
      look(16'h02F8, 8'd9);
      chk("R5 below edge hit", int'(ovl_hit), 1);
      chk("R5 below edge idx", int'(ovl_idx), 3);
      look(16'h030F, 8'd1);
      chk("R5 last byte hit", int'(ovl_hit), 1);
      look(16'h0310, 8'd1);
      chk("R5 past end miss", int'(ovl_hit), 0);

      now_time = 16'd250;
      #1;
      chk("R4 min time", int'(sel_idx), 1);
      do_op(3'd5, 2'd3, '0, '0, '0, '0, 1'b0);
      chk("R8 promoted wins", int'(sel_idx), 3);
      do_op(3'd5, 2'd1, '0, '0, '0, '0, 1'b0);
      chk("R8 last promoted wins", int'(sel_idx), 1);
      do_op(3'd3, 2'd3, '0, '0, '0, '0, 1'b0);
      look(16'h0300, 8'd1);
      chk("R5 in service excluded", int'(ovl_hit), 0);
      chk("R3 in service still found", int'(match_hit), 1);
      do_op(3'd6, 2'd1, '0, '0, '0, 2'd1, 1'b0);
      chk("R10 in-service kept", int'(alloc_cnt), 2);

      // earliest allocation wins exact lookup
      do_reset();
      do_op(3'd1, 2'd0, 16'h0700, 8'd4, 16'd5, 2'd0, 1'b0);
      do_op(3'd1, 2'd0, 16'h0700, 8'd4, 16'd5, 2'd0, 1'b0);
      do_op(3'd2, 2'd0, '0, '0, '0, '0, 1'b0);
      chk("R2 freed reused next", int'(alloc_idx), 0);
      do_op(3'd1, 2'd0, 16'h0700, 8'd4, 16'd5, 2'd0, 1'b0);
      look(16'h0700, 8'd1);
      chk("R3 earliest allocated", int'(match_idx), 1);
      do_op(3'd1, 2'd0, 16'h0800, 8'd4, 16'd5, 2'd0, 1'b0);
      chk("R1 not full at three", int'(full), 0);
      do_op(3'd1, 2'd0, 16'h0900, 8'd4, 16'd5, 2'd0, 1'b0);
      chk("R1 full at four", int'(full), 1);
      chk("R11 allocate count", int'(alloc_cnt), 4);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule